// File: doc/BRIEF.md
# Frame and Signal Loss Alarms

This block turns the raw framing status of a received STS-1 byte stream into three alarms. A framer reports, cycle by cycle, whether it is out of frame. An 8 kHz frame tick gives the time base. The block turns that status into a held out-of-frame alarm and a loss-of-frame alarm. Loss of frame means the out-of-frame state has lasted a long time without a break. Both alarms stay up for a minimum time after they rise, so that brief events are not lost.

In the same block, the received data bytes are watched for a run of all-ones or all-zeros bytes. When the run grows longer than a provisioned 8-bit threshold, a loss-of-signal alarm is raised. A threshold of zero turns this alarm off. All timing is counted in frame ticks: 24 ticks for loss of frame and 4 ticks for the hold time by default.

Top module: `frame_sig_alarms`

## Requirements
- R1: `oof_alarm` is high in the cycle after any cycle in which `oof_in` is sampled high.
- R2: Once `oof_alarm` rises, it stays high until `HOLD_TICKS` frame ticks have been counted since it rose. It falls in the cycle after a cycle in which both that hold is complete and `oof_in` is low.
- R3: A persistence counter counts frame ticks while `oof_in` is high, up to `LOF_TICKS`. `lof_alarm` rises in the cycle after a cycle in which `oof_in` is high and that count has reached `LOF_TICKS`.
- R4: Any single cycle with `oof_in` low clears the persistence count to zero, so the full `LOF_TICKS` must elapse again.
- R5: `lof_alarm` follows the same minimum hold as R2. It stays high for `HOLD_TICKS` ticks after it rises, then falls in the cycle after its condition is found absent.
- R6: On each cycle with `byte_vld` high, a byte of 0xFF or 0x00 extends the run by one if it equals the previous byte of the run. Otherwise it starts a new run of length one. Any other value sets the run to zero. Cycles with `byte_vld` low leave the run unchanged.
- R7: `los_alarm` is high exactly when the current run length is strictly greater than `los_thr`. It responds to a change of `los_thr` in the same cycle.
- R8: When `los_thr` is 0x00, `los_alarm` is low whatever the byte stream.
- R9: The run length saturates at 255 and never wraps. A threshold of 255 therefore never raises `los_alarm`, and a threshold of 254 stays raised during an endless run.
- R10: While `rst_n` is low at a clock edge, all three alarms and all counters are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oof_in | input | 1 | Raw out-of-frame status from the framer |
| frame_tick | input | 1 | One-cycle pulse every 125 µs |
| byte_vld | input | 1 | Received byte strobe |
| byte_in | input | 8 | Received data byte |
| los_thr | input | 8 | Run-length threshold for loss of signal; 0 disables |
| oof_alarm | output | 1 | Held out-of-frame alarm |
| lof_alarm | output | 1 | Held loss-of-frame alarm |
| los_alarm | output | 1 | Loss-of-signal alarm |

## Verification
The assertions assume that `frame_tick` is a single-cycle pulse with at least one idle cycle between pulses. They also assume that `oof_in`, `byte_vld`, `byte_in` and `los_thr` are stable around each sampling edge. The bench drives every input on the falling clock edge and makes frame ticks one cycle wide with a period of eight cycles. It changes the threshold only between bytes, so the same-cycle threshold response is seen on its own.

// File: rtl/frame_sig_alarms.sv
module frame_sig_alarms #(
  parameter int LOF_TICKS  = 24,
  parameter int HOLD_TICKS = 4,
  parameter int BYTE_W     = 8,
  parameter int RUN_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oof_in,
  input  logic              frame_tick,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [RUN_W-1:0]  los_thr,
  output logic              oof_alarm,
  output logic              lof_alarm,
  output logic              los_alarm
);
  localparam int PERS_W = $clog2(LOF_TICKS + 1);
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
  localparam logic [PERS_W-1:0] PERS_LIM = PERS_W'(LOF_TICKS);
  localparam logic [HOLD_W-1:0] HOLD_LIM = HOLD_W'(HOLD_TICKS);
  localparam logic [RUN_W-1:0]  RUN_MAX  = '1;

  // R3/R4 persistence of the out-of-frame state
  logic [PERS_W-1:0] pers;
  logic              lof_cond;

  always_ff @(posedge clk) begin
    if (!rst_n || !oof_in)
      pers <= '0;
    else if (frame_tick && pers != PERS_LIM)
      pers <= pers + 1'b1;
  end

  assign lof_cond = oof_in && (pers == PERS_LIM);

  // R2/R5 minimum-hold alarm stages, index 0 = out of frame, 1 = loss of frame
  logic [1:0] cond, held;
  assign cond = {lof_cond, oof_in};

  for (genvar g = 0; g < 2; g++) begin : g_hold
    logic [HOLD_W-1:0] hcnt;
    logic              on;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on   <= 1'b0;
        hcnt <= '0;
      end else if (!on) begin
        hcnt <= '0;
        if (cond[g]) on <= 1'b1;
      end else begin
        if (frame_tick && hcnt != HOLD_LIM) hcnt <= hcnt + 1'b1;
        if (!cond[g] && hcnt == HOLD_LIM) on <= 1'b0;
      end
    end
    assign held[g] = on;
  end

  assign oof_alarm = held[0];
  assign lof_alarm = held[1];

  // R6/R9 uniform-byte run length
  logic [RUN_W-1:0] run;
  logic             run_ones;
  logic             uniform, same_kind;

  assign uniform   = (byte_in == '1) || (byte_in == '0);
  assign same_kind = (run != '0) && (byte_in[0] == run_ones);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= '0;
      run_ones <= 1'b0;
    end else if (byte_vld) begin
      if (!uniform)
        run <= '0;
      else begin
        run_ones <= byte_in[0];
        if (!same_kind)
          run <= RUN_W'(1);
        else if (run != RUN_MAX)
          run <= run + 1'b1;
      end
    end
  end

  // R7/R8
  assign los_alarm = (los_thr != '0) && (run > los_thr);
endmodule

module frame_sig_alarms_chk #(
  parameter int BYTE_W = 8,
  parameter int RUN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oof_in,
  input logic              byte_vld,
  input logic [BYTE_W-1:0] byte_in,
  input logic [RUN_W-1:0]  los_thr,
  input logic              oof_alarm,
  input logic              lof_alarm,
  input logic              los_alarm
);
  a_r1_oof_follows: assert property (@(posedge clk) disable iff (!rst_n)
    oof_in |=> oof_alarm);

  a_r2_oof_clear_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof_alarm) |-> !$past(oof_in));

  a_r3_lof_needs_oof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof_alarm) |-> $past(oof_in));

  a_r6_mixed_byte_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_in != '1 && byte_in != '0) |=> !los_alarm);

  a_r8_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (los_thr == '0) |-> !los_alarm);

  a_r9_max_never: assert property (@(posedge clk) disable iff (!rst_n)
    (los_thr == '1) |-> !los_alarm);

  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!oof_alarm && !lof_alarm && !los_alarm) || !rst_n);
endmodule

bind frame_sig_alarms frame_sig_alarms_chk #(.BYTE_W(BYTE_W), .RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oof_in(oof_in), .byte_vld(byte_vld),
  .byte_in(byte_in), .los_thr(los_thr), .oof_alarm(oof_alarm),
  .lof_alarm(lof_alarm), .los_alarm(los_alarm)
);

// File: tb/sim_frame_sig_alarms.sv
`timescale 1ns/1ps
module sim_frame_sig_alarms;
  logic clk = 0, rst_n = 0, oof_in = 0, frame_tick = 0, byte_vld = 0;
  logic [7:0] byte_in = 8'h5a, los_thr = 8'd0;
  logic oof_alarm, lof_alarm, los_alarm;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  frame_sig_alarms u0 (.clk(clk), .rst_n(rst_n), .oof_in(oof_in), .frame_tick(frame_tick),
    .byte_vld(byte_vld), .byte_in(byte_in), .los_thr(los_thr),
    .oof_alarm(oof_alarm), .lof_alarm(lof_alarm), .los_alarm(los_alarm));

  // behavioural reference
  int  m_oof = 0, m_lof = 0, m_ohold = 0, m_lhold = 0, m_pers = 0, m_run = 0, m_last = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_oof = 0; m_lof = 0; m_ohold = 0; m_lhold = 0; m_pers = 0; m_run = 0;
    end else begin
      bit lc, oclr, lclr;
      lc   = oof_in && m_pers >= 24;
      oclr = m_oof && !oof_in && m_ohold >= 4;
      lclr = m_lof && !lc && m_lhold >= 4;
      if (!m_oof) begin m_ohold = 0; if (oof_in) m_oof = 1; end
      else begin if (frame_tick && m_ohold < 4) m_ohold++; if (oclr) m_oof = 0; end
      if (!m_lof) begin m_lhold = 0; if (lc) m_lof = 1; end
      else begin if (frame_tick && m_lhold < 4) m_lhold++; if (lclr) m_lof = 0; end
      if (!oof_in) m_pers = 0; else if (frame_tick && m_pers < 24) m_pers++;
      if (byte_vld) begin
        if (byte_in == 8'hff || byte_in == 8'h00) begin
          if (m_run > 0 && int'(byte_in) == m_last) m_run = (m_run < 255) ? m_run + 1 : 255;
          else m_run = 1;
          m_last = int'(byte_in);
        end else m_run = 0;
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, R1 R3 R7 carry the three outputs
  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      chk("R1 oof", oof_alarm, logic'(m_oof != 0));
      chk("R3 lof", lof_alarm, logic'(m_lof != 0));
      chk("R7 los", los_alarm, logic'(los_thr != 0 && m_run > int'(los_thr)));
    end
    if (cyc > 150000 && !done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // frame tick generator: one cycle in eight
  initial begin
    forever begin
      repeat (7) @(negedge clk);
      frame_tick = 1;
      @(negedge clk);
      frame_tick = 0;
    end
  end

  task automatic ticks(int n);
    repeat (n * 8) @(negedge clk);
  endtask

  task automatic send(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_vld = 1; byte_in = b;
    end
    @(negedge clk); byte_vld = 0; byte_in = 8'h3c;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R10 oof reset", oof_alarm, 0);
    chk("R10 lof reset", lof_alarm, 0);
    chk("R10 los reset", los_alarm, 0);
    rst_n = 1;

    // R2: single-cycle out-of-frame pulse is stretched
    @(negedge clk); oof_in = 1; @(negedge clk); oof_in = 0;
    ticks(2); chk("R2 held", oof_alarm, 1);
    ticks(4); chk("R2 released", oof_alarm, 0);

    // R4: broken persistence
    oof_in = 1; ticks(20);
    oof_in = 0; @(negedge clk); oof_in = 1;
    ticks(20); chk("R4 no lof after break", lof_alarm, 0);
    ticks(6); chk("R3 lof after full window", lof_alarm, 1);

    // R5: drop as soon as lof rises, hold must remain
    oof_in = 0; ticks(6);
    oof_in = 1;
    while (!lof_alarm) @(negedge clk);
    oof_in = 0;
    ticks(2); chk("R5 lof held", lof_alarm, 1);
    ticks(4); chk("R5 lof released", lof_alarm, 0);

    // R6/R7 runs
    los_thr = 8'd5;
    send(8'hff, 5); chk("R7 equal not over", los_alarm, 0);
    send(8'hff, 1); chk("R7 over", los_alarm, 1);
    repeat (5) @(negedge clk); chk("R6 idle ignored", los_alarm, 1);
    send(8'h00, 3); chk("R6 kind change restarts", los_alarm, 0);
    send(8'h00, 3); chk("R6 same kind grows", los_alarm, 1);
    send(8'h5a, 1); chk("R6 mixed clears", los_alarm, 0);
    los_thr = 8'd0; send(8'hff, 20); chk("R8 zero disables", los_alarm, 0);
    los_thr = 8'd3; #1 chk("R7 thr same cycle", los_alarm, 1);

    // R9 saturation
    los_thr = 8'd255; send(8'hff, 300); chk("R9 255 never", los_alarm, 0);
    los_thr = 8'd254; #1 chk("R9 254 holds", los_alarm, 1);
    send(8'hff, 10); chk("R9 no wrap", los_alarm, 1);

    // R10 mid-run reset
    oof_in = 1; @(negedge clk); rst_n = 0; oof_in = 0; @(negedge clk); @(negedge clk);
    chk("R10 cleared oof", oof_alarm, 0);
    chk("R10 cleared los", los_alarm, 0);
    rst_n = 1; ticks(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule